// File: doc/BRIEF.md
# Read-Modify-Write Atomic ALU

This unit sits next to a memory bank and executes one atomic operation per request on a single data word. The requester presents an opcode, a primary operand, a compare operand and the word currently held in memory. The unit computes the word that is to be written back. For opcodes of the returning kind it also hands the pre-operation word back to the requester. The memory array, address handling and lane merging live outside the block.

Eleven operations are available: bitwise AND, OR and XOR, compare-and-swap, exchange, wrapping add and subtract, increment, decrement, and a strict maximum and minimum. The ordering used by maximum and minimum is chosen per request, either signed or unsigned. Each operation has two opcodes. Both compute the same result, and they differ only in whether a response carries the old word back. Two counters record how many compare-and-swap operations were executed and how many of them found a mismatch. The unit accepts a request in every cycle after reset, and all results appear in registers one cycle after acceptance.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The opcode is 5 bits wide. Bits [3:0] select the function: 0 AND, 1 OR, 2 XOR, 3 compare-and-swap, 4 exchange, 5 add, 6 subtract, 7 increment, 8 decrement, 9 max, 10 min. Bit 4 set means non-returning. Function codes 11 to 15 are illegal. An illegal request pulses `err` for one cycle, produces no write-back and no response, and leaves the counters unchanged.
- R2: AND, OR and XOR write back the bitwise combination of the memory word and `req_a`.
- R3: Add and subtract write back memory plus or minus `req_a`, modulo 2^WIDTH. Increment and decrement add or subtract one with the same wrap, and they ignore `req_a` and `req_c`.
- R4: Exchange writes back `req_a` whatever the memory word is.
- R5: Compare-and-swap writes back `req_a` when the memory word equals `req_c`. Otherwise it writes back the memory word unchanged.
- R6: Every accepted compare-and-swap, returning or not, adds one to `cas_tries`. One whose comparison fails also adds one to `cas_fails`. No other request changes either counter.
- R7: Max writes `req_a` only when `req_a` is strictly greater than the memory word, and min only when it is strictly smaller. With `req_signed`=1 both compare as two's complement; with `req_signed`=0 they compare as unsigned.
- R8: An accepted legal request raises `wb_valid` with `wb_data` for exactly the cycle after acceptance. A cycle without `req_valid` raises neither `wb_valid`, `rsp_valid` nor `err`.
- R9: A returning legal request raises `rsp_valid` together with `wb_valid`, and `rsp_data` holds the memory word as it was before the operation. A non-returning request never raises `rsp_valid`.
- R10: While reset is held, and in the first cycle after it, `wb_valid`, `rsp_valid` and `err` are low and both counters are zero. `req_ready` is high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 5 | Opcode: function in [3:0], non-returning flag in [4] |
| req_signed | input | 1 | Signed ordering for max and min |
| req_a | input | WIDTH | Primary operand, also the swap value |
| req_c | input | WIDTH | Compare operand for compare-and-swap |
| req_mem | input | WIDTH | Current memory word |
| wb_valid | output | 1 | Write-back word valid |
| wb_data | output | WIDTH | Word to store back |
| rsp_valid | output | 1 | Old-value response valid |
| rsp_data | output | WIDTH | Memory word before the operation |
| err | output | 1 | Illegal opcode seen |
| cas_tries | output | CNT_W | Compare-and-swap count |
| cas_fails | output | CNT_W | Failed compare-and-swap count |

## Verification
A returning compare-and-swap produces a response and bumps the counters in the same cycle, and a mismatching one bumps both counters at once while the write-back carries the unchanged word. The bench provokes this by sweeping every compare operand against every memory word for both opcode variants back to back at a 4-bit width. In each result cycle it judges the response, the write-back and both counter values together against totals it keeps on its own.

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [4:0]       req_op,
  input  logic             req_signed,
  input  logic [WIDTH-1:0] req_a,
  input  logic [WIDTH-1:0] req_c,
  input  logic [WIDTH-1:0] req_mem,
  output logic             wb_valid,
  output logic [WIDTH-1:0] wb_data,
  output logic             rsp_valid,
  output logic [WIDTH-1:0] rsp_data,
  output logic             err,
  output logic [CNT_W-1:0] cas_tries,
  output logic [CNT_W-1:0] cas_fails
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [3:0]       fn;
  logic             legal, accept, is_cas, cas_hit, a_gt, a_lt;
  logic [WIDTH-1:0] nxt;

  assign fn      = req_op[3:0];
  assign legal   = fn <= 4'd10;
  assign accept  = req_valid & req_ready;
  assign is_cas  = fn == 4'd3;
  assign cas_hit = req_mem == req_c;
  assign a_gt    = req_signed ? ($signed(req_a) > $signed(req_mem)) : (req_a > req_mem);
  assign a_lt    = req_signed ? ($signed(req_a) < $signed(req_mem)) : (req_a < req_mem);

  always_comb begin
    nxt = req_mem;
    case (fn)
      4'd0:    nxt = req_mem & req_a;
      4'd1:    nxt = req_mem | req_a;
      4'd2:    nxt = req_mem ^ req_a;
      4'd3:    nxt = cas_hit ? req_a : req_mem;
      4'd4:    nxt = req_a;
      4'd5:    nxt = req_mem + req_a;
      4'd6:    nxt = req_mem - req_a;
      4'd7:    nxt = req_mem + ONE;
      4'd8:    nxt = req_mem - ONE;
      4'd9:    nxt = a_gt ? req_a : req_mem;
      4'd10:   nxt = a_lt ? req_a : req_mem;
      default: nxt = req_mem;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      wb_valid  <= 1'b0;
      wb_data   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err       <= 1'b0;
      cas_tries <= '0;
      cas_fails <= '0;
    end else begin
      req_ready <= 1'b1;
      wb_valid  <= accept & legal;
      rsp_valid <= accept & legal & ~req_op[4];
      err       <= accept & ~legal;
      if (accept) begin
        wb_data  <= nxt;
        rsp_data <= req_mem;
      end
      if (accept && is_cas) begin
        cas_tries <= cas_tries + CNT_ONE;
        if (!cas_hit) cas_fails <= cas_fails + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [4:0]       req_op,
  input logic [WIDTH-1:0] req_a,
  input logic [WIDTH-1:0] req_mem,
  input logic             wb_valid,
  input logic [WIDTH-1:0] wb_data,
  input logic             rsp_valid,
  input logic [WIDTH-1:0] rsp_data,
  input logic             err,
  input logic [CNT_W-1:0] cas_tries,
  input logic [CNT_W-1:0] cas_fails
);
  logic acc;
  assign acc = req_valid & req_ready;

  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wb_valid && !rsp_valid)); // R1
  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op[3:0] > 4'd10) |=> err); // R1
  AST_XCHG_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op[3:0] == 4'd4) |=> (wb_valid && wb_data == $past(req_a))); // R4
  AST_FAIL_NEEDS_TRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fails != $past(cas_fails)) |-> (cas_tries != $past(cas_tries))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!wb_valid && !rsp_valid && !err)); // R8
  AST_RSP_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> wb_valid); // R9
  AST_RSP_OLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_op[4] && req_op[3:0] <= 4'd10) |=> (rsp_valid && rsp_data == $past(req_mem))); // R9
  AST_NORET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op[4]) |=> !rsp_valid); // R9
endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_a(req_a), .req_mem(req_mem), .wb_valid(wb_valid),
  .wb_data(wb_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err),
  .cas_tries(cas_tries), .cas_fails(cas_fails)
);

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
  localparam int W = 4;
  localparam int CW = 16;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0] req_op = '0;
  logic req_signed = 1'b0;
  logic [W-1:0] req_a = '0, req_c = '0, req_mem = '0;
  logic wb_valid, rsp_valid, err;
  logic [W-1:0] wb_data, rsp_data;
  logic [CW-1:0] cas_tries, cas_fails;

  int n_checks = 0;
  int n_fail = 0;
  int exp_tries = 0;
  int exp_fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  atomic_rmw_unit #(.WIDTH(W), .CNT_W(CW)) i_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_signed(req_signed), .req_a(req_a), .req_c(req_c),
    .req_mem(req_mem), .wb_valid(wb_valid), .wb_data(wb_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err),
    .cas_tries(cas_tries), .cas_fails(cas_fails)
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v > M / 2) ? v - (M + 1) : v;
  endfunction

  function automatic string tag_of(int fn);
    if (fn <= 2) return "R2";
    if (fn == 3) return "R5";
    if (fn == 4) return "R4";
    if (fn <= 8) return "R3";
    if (fn <= 10) return "R7";
    return "R1";
  endfunction

  task automatic run(int op, int s, int a, int c, int m);
    int fn, nw;
    bit ret, legal;
    fn = op & 15;
    ret = (op & 16) == 0;
    legal = fn <= 10;
    req_valid = 1'b1;
    req_op = op[4:0];
    req_signed = s[0];
    req_a = a[W-1:0];
    req_c = c[W-1:0];
    req_mem = m[W-1:0];
    case (fn)
      0: nw = m & a;
      1: nw = m | a;
      2: nw = m ^ a;
      3: nw = (m == c) ? a : m;
      4: nw = a;
      5: nw = (m + a) & M;
      6: nw = (m - a) & M;
      7: nw = (m + 1) & M;
      8: nw = (m - 1) & M;
      9: nw = (s != 0 ? sx(a) > sx(m) : a > m) ? a : m;
      10: nw = (s != 0 ? sx(a) < sx(m) : a < m) ? a : m;
      default: nw = m;
    endcase
    if (fn == 3) begin
      exp_tries++;
      if (m != c) exp_fails++;
    end
    @(negedge clk);
    chk(legal ? "R8 wb_valid" : "R1 wb_valid", int'(wb_valid), int'(legal));
    chk("R1 err", int'(err), int'(!legal));
    chk("R9 rsp_valid", int'(rsp_valid), int'(legal && ret));
    if (legal) chk(tag_of(fn), int'(wb_data), nw);
    if (legal && ret) chk("R9 rsp_data", int'(rsp_data), m);
    chk("R6 cas_tries", int'(cas_tries), exp_tries);
    chk("R6 cas_fails", int'(cas_fails), exp_fails);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 wb_valid", int'(wb_valid), 0);
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 tries", int'(cas_tries), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 req_ready", int'(req_ready), 1);
    chk("R10 fails", int'(cas_fails), 0);
    chk("R10 wb_valid after", int'(wb_valid), 0);
    for (int op = 0; op < 32; op++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a <= M; a++)
          for (int m = 0; m <= M; m++)
            run(op, s, a, a ^ m ^ 5, m);
    for (int op = 3; op < 32; op += 16)
      for (int c = 0; c <= M; c++)
        for (int a = 0; a <= M; a += 5)
          for (int m = 0; m <= M; m++)
            run(op, 0, a, c, m);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle wb_valid", int'(wb_valid), 0);
    chk("R8 idle rsp_valid", int'(rsp_valid), 0);
    chk("R8 idle err", int'(err), 0);
    chk("R6 idle tries", int'(cas_tries), exp_tries);
    finish_up();
  end
endmodule